// File: doc/BRIEF.md
# Occupancy-Driven Buffer Tier Power Controller

This block decides which tiers of a packet buffer have power. The buffer has three tiers: a small on-chip store that is always powered, an SRAM tier, and a DRAM tier that is split into rows behind one DRAM controller. On every cycle the block blends the live occupancy with the total buffer size into a target capacity. A single fractional coefficient sets the blend. The block then moves a tier ladder by at most one step toward that target.

The ladder has a fixed order. Level 0 is the on-chip store alone. Level 1 adds the SRAM. Level 2 adds the DRAM controller together with row 0. Each higher level adds the next DRAM row. Shedding walks down from the highest row, puts the controller to sleep with row 0, and only then puts the SRAM to sleep. Restoring walks up in the reverse order.

Each DRAM row reports a power state, and rows that are awake but unused show as idle. The summed size of all awake tiers is given to the enqueue logic as an admission limit. The tier sizes, the hysteresis margin and the idle limit are configuration inputs and are expected to stay static while the block runs.

Top module: `buf_tier_power`

## Requirements
- R1: During and right after reset, every tier is awake, the admission limit equals the total of all tier sizes, every row reports active (code 2), and the target output holds all ones.
- R2: The target output equals floor((alpha·occ + (256−alpha)·total) / 256), where alpha is an 8-bit fraction of 256. It appears one clock after the inputs that produce it.
- R3: With alpha held at 0, no tier is ever put to sleep and the admission limit stays at the total.
- R4: At most one ladder step happens per clock. Shedding order is DRAM row 3, row 2, row 1, then row 0 together with the DRAM controller, then the SRAM. The on-chip tier never sleeps.
- R5: Restoring order is SRAM, then the DRAM controller with row 0, then rows 1, 2 and 3.
- R6: A step down happens only when two conditions hold in the same cycle: the registered target is at or below the capacity of the tiers that would remain, and the present occupancy is strictly below that capacity.
- R7: A step up happens when the registered target exceeds the present capacity plus the hysteresis margin. Wake has priority over sleep.
- R8: The admission limit equals the on-chip size, plus the SRAM size when the SRAM is awake, plus the row size for each awake DRAM row.
- R9: Each row reports a 2-bit state: 0 for sleep, 1 for idle, 2 for active. An awake row becomes idle after idleLimit clocks without access. Its count restarts on an access and while the row sleeps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| occBytes | input | 20 | Current buffer occupancy in bytes |
| alpha | input | 8 | Blend coefficient, value/256 |
| onChipBytes | input | 20 | Size of the always-on tier |
| sramBytes | input | 20 | Size of the SRAM tier |
| dramRowBytes | input | 20 | Size of one DRAM row |
| hystBytes | input | 20 | Hysteresis margin added to the wake threshold |
| idleLimit | input | 16 | Idle clocks before an awake row reports idle |
| rowAccess | input | 4 | Per-row read/write activity this cycle |
| targetCap | output | 20 | Registered target capacity |
| admitLimit | output | 20 | Capacity of all awake tiers |
| sramWake | output | 1 | SRAM power enable (1 = active) |
| dramCtrlWake | output | 1 | DRAM controller power enable |
| rowWake | output | 4 | Per-row power enables |
| rowState | output | 8 | Per-row 2-bit power state, row 0 in the low bits |

## Verification
The hardest case to reach is a step down that is refused only because of occupancy. The target tracks occupancy closely, so the target is low only when occupancy is also low. The stimulus gets there through the one-cycle lag of the registered target. Alpha jumps to its maximum while occupancy is zero, and in the very next cycle occupancy leaps above the capacity that would remain. At that point the target is already low, but the present occupancy forbids the step. Long runs of random occupancy, coefficient and row activity are then compared against a behavioural model on every clock.

// File: rtl/tier_pwr_pkg.sv
package tier_pwr_pkg;

  typedef struct packed {
    logic stepUp;
    logic stepDown;
  } tierStrobe_t;

  typedef enum logic [1:0] {
    ROW_SLEEP  = 2'd0,
    ROW_IDLE   = 2'd1,
    ROW_ACTIVE = 2'd2
  } rowPwr_t;

endpackage

// File: rtl/tier_capacity_dp.sv
module tier_capacity_dp
  import tier_pwr_pkg::*;
#(
  parameter int OCC_W    = 20,
  parameter int ALPHA_W  = 8,
  parameter int NUM_ROWS = 4,
  parameter int LVL_W    = $clog2(NUM_ROWS + 2)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [OCC_W-1:0]   occBytes,
  input  logic [ALPHA_W-1:0] alpha,
  input  logic [OCC_W-1:0]   onChipBytes,
  input  logic [OCC_W-1:0]   sramBytes,
  input  logic [OCC_W-1:0]   dramRowBytes,
  input  logic [OCC_W-1:0]   hystBytes,
  input  tierStrobe_t        strobe,
  output logic [OCC_W-1:0]   targetCap,
  output logic [OCC_W-1:0]   admitLimit,
  output logic [LVL_W-1:0]   level,
  output logic               canWake,
  output logic               canSleep
);
  localparam int MAX_LVL = NUM_ROWS + 1;
  localparam int TBL_N   = 2 ** LVL_W;
  localparam int PROD_W  = OCC_W + ALPHA_W + 1;
  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(MAX_LVL);

  logic [OCC_W-1:0]   capTable [TBL_N];
  logic [OCC_W-1:0]   totalBytes, capCur, capBelow, targetQ;
  logic [LVL_W-1:0]   levelQ;
  logic [ALPHA_W:0]   alphaComp;
  logic [PROD_W-1:0]  blend;

  // capacity of each ladder level
  assign capTable[0] = onChipBytes;
  assign capTable[1] = onChipBytes + sramBytes;
  for (genvar k = 2; k < TBL_N; k++) begin : g_cap
    if (k <= MAX_LVL) begin : g_row
      assign capTable[k] = capTable[k-1] + dramRowBytes;
    end else begin : g_pad
      assign capTable[k] = capTable[k-1];
    end
  end

  assign totalBytes = capTable[MAX_LVL];
  assign capCur     = capTable[levelQ];
  assign capBelow   = (levelQ == '0) ? capTable[0] : capTable[levelQ - LVL_W'(1)];

  // single multiply-add blend
  assign alphaComp = (ALPHA_W+1)'(1 << ALPHA_W) - {1'b0, alpha};
  assign blend = PROD_W'(alpha) * PROD_W'(occBytes)
               + PROD_W'(alphaComp) * PROD_W'(totalBytes);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      targetQ <= '1;
    end else begin
      targetQ <= blend[ALPHA_W +: OCC_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelQ <= TOP_LVL;
    end else if (strobe.stepUp) begin
      levelQ <= levelQ + LVL_W'(1);
    end else if (strobe.stepDown) begin
      levelQ <= levelQ - LVL_W'(1);
    end
  end

  assign canWake  = (levelQ != TOP_LVL) &&
                    ({1'b0, targetQ} > ({1'b0, capCur} + {1'b0, hystBytes}));
  assign canSleep = (levelQ != '0) && (targetQ <= capBelow) && (occBytes < capBelow);

  assign targetCap  = targetQ;
  assign admitLimit = capCur;
  assign level      = levelQ;

  // R4
  step_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(levelQ) |-> (levelQ == $past(levelQ) + LVL_W'(1)) ||
                         (levelQ == $past(levelQ) - LVL_W'(1)));

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.stepUp, strobe.stepDown}));

  // R6
  sleep_safe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (levelQ < $past(levelQ)) |-> ($past(occBytes) < capCur));

  // R3
  no_full_sleep_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stepDown |-> (targetQ < totalBytes));

endmodule

// File: rtl/tier_sequencer.sv
module tier_sequencer
  import tier_pwr_pkg::*;
#(
  parameter int NUM_ROWS = 4,
  parameter int LVL_W    = $clog2(NUM_ROWS + 2)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [LVL_W-1:0]    level,
  input  logic                canWake,
  input  logic                canSleep,
  output tierStrobe_t         strobe,
  output logic                sramWake,
  output logic                dramCtrlWake,
  output logic [NUM_ROWS-1:0] rowWake
);
  // wake wins over sleep
  always_comb begin
    strobe.stepUp   = canWake;
    strobe.stepDown = canSleep & ~canWake;
  end

  assign sramWake     = (level >= LVL_W'(1));
  assign dramCtrlWake = (level >= LVL_W'(2));

  for (genvar i = 0; i < NUM_ROWS; i++) begin : g_row
    assign rowWake[i] = (level >= LVL_W'(i + 2));
  end

  // R5
  ctrl_after_sram_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dramCtrlWake) |-> $past(sramWake));

  // R4
  sram_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sramWake) |-> !$past(dramCtrlWake));

  for (genvar i = 1; i < NUM_ROWS; i++) begin : g_ord
    // R5
    row_up_order_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(rowWake[i]) |-> $past(rowWake[i-1]));
    // R4
    row_down_order_chk: assert property (@(posedge clk) disable iff (!rstN)
      $fell(rowWake[i-1]) |-> !$past(rowWake[i]));
  end

endmodule

// File: rtl/row_activity.sv
module row_activity
  import tier_pwr_pkg::*;
#(
  parameter int NUM_ROWS = 4,
  parameter int IDLE_W   = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_ROWS-1:0]   rowWake,
  input  logic [NUM_ROWS-1:0]   rowAccess,
  input  logic [IDLE_W-1:0]     idleLimit,
  output logic [2*NUM_ROWS-1:0] rowState
);
  localparam logic [IDLE_W-1:0] CNT_MAX = '1;

  for (genvar i = 0; i < NUM_ROWS; i++) begin : g_row
    logic [IDLE_W-1:0] quietCnt;
    rowPwr_t           pwr;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        quietCnt <= '0;
      end else if (!rowWake[i] || rowAccess[i]) begin
        quietCnt <= '0;
      end else if (quietCnt != CNT_MAX) begin
        quietCnt <= quietCnt + IDLE_W'(1);
      end
    end

    always_comb begin
      if (!rowWake[i])                pwr = ROW_SLEEP;
      else if (quietCnt >= idleLimit) pwr = ROW_IDLE;
      else                            pwr = ROW_ACTIVE;
    end

    assign rowState[2*i +: 2] = pwr;

    // R9
    busy_row_active_chk: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rowAccess[i]) && $past(rowWake[i]) && rowWake[i] && (idleLimit != '0))
        |-> (pwr == ROW_ACTIVE));
  end

endmodule

// File: rtl/buf_tier_power.sv
module buf_tier_power
  import tier_pwr_pkg::*;
#(
  parameter int OCC_W    = 20,
  parameter int ALPHA_W  = 8,
  parameter int NUM_ROWS = 4,
  parameter int IDLE_W   = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [OCC_W-1:0]      occBytes,
  input  logic [ALPHA_W-1:0]    alpha,
  input  logic [OCC_W-1:0]      onChipBytes,
  input  logic [OCC_W-1:0]      sramBytes,
  input  logic [OCC_W-1:0]      dramRowBytes,
  input  logic [OCC_W-1:0]      hystBytes,
  input  logic [IDLE_W-1:0]     idleLimit,
  input  logic [NUM_ROWS-1:0]   rowAccess,
  output logic [OCC_W-1:0]      targetCap,
  output logic [OCC_W-1:0]      admitLimit,
  output logic                  sramWake,
  output logic                  dramCtrlWake,
  output logic [NUM_ROWS-1:0]   rowWake,
  output logic [2*NUM_ROWS-1:0] rowState
);
  localparam int LVL_W = $clog2(NUM_ROWS + 2);

  tierStrobe_t      strobe;
  logic [LVL_W-1:0] level;
  logic             canWake, canSleep;
  logic [OCC_W-1:0] awakeSum;

  tier_capacity_dp #(
    .OCC_W(OCC_W), .ALPHA_W(ALPHA_W), .NUM_ROWS(NUM_ROWS), .LVL_W(LVL_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .occBytes(occBytes), .alpha(alpha),
    .onChipBytes(onChipBytes), .sramBytes(sramBytes), .dramRowBytes(dramRowBytes),
    .hystBytes(hystBytes), .strobe(strobe), .targetCap(targetCap),
    .admitLimit(admitLimit), .level(level), .canWake(canWake), .canSleep(canSleep)
  );

  tier_sequencer #(.NUM_ROWS(NUM_ROWS), .LVL_W(LVL_W)) u_seq (
    .clk(clk), .rstN(rstN), .level(level), .canWake(canWake), .canSleep(canSleep),
    .strobe(strobe), .sramWake(sramWake), .dramCtrlWake(dramCtrlWake), .rowWake(rowWake)
  );

  row_activity #(.NUM_ROWS(NUM_ROWS), .IDLE_W(IDLE_W)) u_act (
    .clk(clk), .rstN(rstN), .rowWake(rowWake), .rowAccess(rowAccess),
    .idleLimit(idleLimit), .rowState(rowState)
  );

  assign awakeSum = onChipBytes + (sramWake ? sramBytes : '0)
                  + OCC_W'($countones(rowWake)) * dramRowBytes;

  // R8
  admit_sum_chk: assert property (@(posedge clk) disable iff (!rstN)
    admitLimit == awakeSum);

  // R4
  ctrl_with_rows_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|rowWake) == dramCtrlWake);

endmodule

// File: tb/sim_buf_tier_power.sv
`timescale 1ns/100ps
module sim_buf_tier_power;
  localparam longint ONCHIP = 16384;
  localparam longint SRAMB  = 81920;
  localparam longint ROWB   = 131072;
  localparam longint TOTAL  = ONCHIP + SRAMB + 4 * ROWB;
  localparam longint HYST   = 4096;
  localparam int     IDLE   = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [19:0] occ = '0;
  logic [7:0]  alpha = '0;
  logic [3:0]  rowAcc = '0;
  logic [19:0] targetCap, admitLimit;
  logic        sramWake, dramCtrlWake;
  logic [3:0]  rowWake;
  logic [7:0]  rowState;

  int nRun = 0;
  int nFail = 0;
  bit finished = 0;

  // behavioural model state
  int     mLevel;
  longint mTgt;
  int     mCnt [4];

  always #2.5 clk = ~clk;

  buf_tier_power u0 (
    .clk(clk), .rstN(rstN), .occBytes(occ), .alpha(alpha),
    .onChipBytes(20'(ONCHIP)), .sramBytes(20'(SRAMB)), .dramRowBytes(20'(ROWB)),
    .hystBytes(20'(HYST)), .idleLimit(16'(IDLE)), .rowAccess(rowAcc),
    .targetCap(targetCap), .admitLimit(admitLimit), .sramWake(sramWake),
    .dramCtrlWake(dramCtrlWake), .rowWake(rowWake), .rowState(rowState)
  );

  function automatic longint capOf(input int l);
    longint c = ONCHIP;
    if (l >= 1) c += SRAMB;
    if (l >= 2) c += longint'(l - 1) * ROWB;
    return c;
  endfunction

  function automatic logic [5:0] enablesOf(input int l);
    logic [5:0] e;
    e[5] = (l >= 1);
    e[4] = (l >= 2);
    for (int i = 0; i < 4; i++) e[i] = (l >= i + 2);
    return e;
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelAdvance();
    longint capC, capB;
    for (int i = 0; i < 4; i++) begin
      if (!(mLevel >= i + 2) || rowAcc[i]) mCnt[i] = 0;
      else if (mCnt[i] < 65535) mCnt[i]++;
    end
    capC = capOf(mLevel);
    capB = (mLevel == 0) ? capOf(0) : capOf(mLevel - 1);
    if (mLevel < 5 && mTgt > capC + HYST) mLevel++;
    else if (mLevel > 0 && mTgt <= capB && longint'(occ) < capB) mLevel--;
    mTgt = (longint'(alpha) * longint'(occ) + (256 - longint'(alpha)) * TOTAL) / 256;
  endtask

  task automatic compareAll();
    logic [7:0] expState;
    for (int i = 0; i < 4; i++) begin
      if (!(mLevel >= i + 2))  expState[2*i +: 2] = 2'd0;
      else if (mCnt[i] >= IDLE) expState[2*i +: 2] = 2'd1;
      else                      expState[2*i +: 2] = 2'd2;
    end
    check("R2 targetCap", longint'(targetCap), mTgt);
    check("R8 admitLimit", longint'(admitLimit), capOf(mLevel));
    check("R4/R5 enables", longint'({sramWake, dramCtrlWake, rowWake}),
          longint'(enablesOf(mLevel)));
    check("R9 rowState", longint'(rowState), longint'(expState));
  endtask

  task automatic step(input longint o, input int a, input logic [3:0] acc);
    @(negedge clk);
    occ = 20'(o);
    alpha = 8'(a);
    rowAcc = acc;
    modelAdvance();
    @(posedge clk);
    #1;
    compareAll();
  endtask

  initial begin
    #(5ns * 100000);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    mLevel = 5;
    mTgt = 64'hFFFFF;
    for (int i = 0; i < 4; i++) mCnt[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 admitLimit", longint'(admitLimit), TOTAL);
    check("R1 enables", longint'({sramWake, dramCtrlWake, rowWake}), 63);
    check("R1 rowState", longint'(rowState), longint'(8'hAA));
    check("R1 targetCap", longint'(targetCap), 64'hFFFFF);
    @(negedge clk);
    rstN = 1'b1;

    // R3: alpha zero keeps everything on whatever the occupancy
    for (int k = 0; k < 40; k++) begin
      step(longint'($urandom_range(0, 600000)), 0, 4'hF);
      check("R3 full capacity", longint'(admitLimit), TOTAL);
    end

    // R4: drain to the on-chip tier one step per clock
    for (int k = 0; k < 10; k++) step(0, 255, 4'h0);
    check("R4 only on-chip left", longint'(admitLimit), ONCHIP);
    check("R4 sram asleep", longint'(sramWake), 0);

    // R5 R7: occupancy rises, tiers return in order up to the hysteresis point
    for (int k = 0; k < 10; k++) step(300000, 255, 4'h0);
    check("R7 level with margin", longint'(admitLimit), capOf(3));

    // R6: refill, then drop the target while occupancy leaps in the next cycle
    for (int k = 0; k < 6; k++) step(0, 0, 4'h0);
    check("R6 refilled", longint'(admitLimit), TOTAL);
    step(0, 255, 4'h0);
    step(600000, 255, 4'h0);
    check("R6 sleep refused by occupancy", longint'(admitLimit), TOTAL);
    step(600000, 255, 4'h0);
    check("R6 still full", longint'(admitLimit), TOTAL);

    // R9: only row 1 sees traffic
    for (int k = 0; k < 12; k++) step(100000, 0, (k % 3 == 0) ? 4'b0010 : 4'b0000);
    check("R9 row0 idle", longint'(rowState[1:0]), 1);
    check("R9 row1 active", longint'(rowState[3:2]), 2);
    check("R9 row3 idle", longint'(rowState[7:6]), 1);

    // mixed traffic against the model
    for (int k = 0; k < 3000; k++) begin
      int a;
      longint o;
      case ($urandom_range(0, 3))
        0: a = 0;
        1: a = 255;
        2: a = 192;
        default: a = int'($urandom_range(0, 255));
      endcase
      if ($urandom_range(0, 7) == 0) o = longint'($urandom_range(0, 1048575));
      else o = longint'($urandom_range(0, 640000));
      step(o, a, 4'($urandom_range(0, 15) & $urandom_range(0, 15) & $urandom_range(0, 15)));
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule